// File: doc/BRIEF.md
# Preemptive DMA Channel Arbiter

This block decides which of several DMA channels the transfer engine serves next. Each channel raises a pending request. When the engine is idle, the arbiter issues a one-cycle grant naming a channel and holds that channel as active until the engine reports completion. Selection works in one of two ways, chosen by a global mode input. In fixed-priority mode the highest priority value wins. In round-robin mode the search rotates from the most recently granted channel, and priority values play no part.

In fixed-priority mode a running channel can be displaced by a more urgent one. This needs consent on both sides: the running channel must allow itself to be suspended, and the challenger must be allowed to preempt. The challenger's permission bit is active-low. The displaced channel is parked in a single suspension slot. It is restarted ahead of any new request whose priority is equal to or lower than its own.

Errors are recorded in sticky state. An error comes either from the engine while a channel is active or from two channels sharing a priority value. With the halt option set, any error halts the arbiter until software clears it. A debug input also holds back new starts. While halted or in debug, a running channel still completes normally.

Top module: `dma_chan_arbiter`

## Requirements
- R1: In fixed-priority mode (`rr_mode_i`=0), with the engine idle and no suspended channel, the requesting channel with the largest priority value is granted; on equal values the lower channel number wins. `grant_o` pulses for one cycle on the clock edge after the request is seen, with `grant_ch_o` set to that channel. `active_o` and `active_ch_o` then hold that channel until the edge at which `done_i`=1 is sampled, after which `active_o` is 0.
- R2: In round-robin mode (`rr_mode_i`=1), the grant goes to the first requesting channel found by counting upward from the last granted channel plus one, wrapping at the top. Priority values are ignored. After reset the last granted channel is taken to be the highest channel number, so channel 0 is searched first.
- R3: In fixed-priority mode a request from channel B preempts active channel A when all three of the following hold: `yield_en_i[A]`=1, the priority of B is strictly greater than the priority of A, and `preempt_dis_i[B]`=0 (this bit is active-low; 1 forbids B from preempting). On the next edge `suspend_o` and `grant_o` both pulse, and `grant_ch_o` and `active_ch_o` become B.
- R4: No preemption takes place in any of these cases: `yield_en_i[A]`=0, `preempt_dis_i[B]`=1, B's priority is not strictly greater than A's, the arbiter is in round-robin mode, or the same edge samples `done_i`=1. Only one channel can be suspended at a time.
- R5: When the engine becomes idle and a channel is suspended, that channel is granted again with `resume_o`=1, and its own request line does not need to be high. A new request wins first only if it is in fixed-priority mode and has a strictly greater priority than the suspended channel; the suspended channel then waits for the next idle cycle.
- R6: `prio_err_o` is 1 one edge after the priority inputs hold two equal values, and 0 one edge after they are all distinct. A duplicate also sets the sticky `err_valid_o`.
- R7: An engine error (`err_i`=1 while `active_o`=1) sets `err_valid_o` and loads `err_ch_o` with the active channel on the next edge. `err_i` is ignored while idle.
- R8: With `halt_on_err_i`=1, any error recorded per R6 or R7 sets `halted_o` on the same edge. While `halted_o`=1, no grant, resume or preemption starts, but the active channel continues and its `done_i` is accepted. `halt_clr_i` clears `halted_o` and `err_valid_o` on the next edge; a new grant can start from the edge after that.
- R9: While `debug_i`=1, no grant, resume or preemption starts, but the active channel keeps running and its `done_i` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | Pending request per channel |
| prio_i | input | NCH*PRIW | Priority value per channel, channel i at bits [i*PRIW +: PRIW] |
| yield_en_i | input | NCH | 1: the channel may be suspended by a more urgent one |
| preempt_dis_i | input | NCH | Active-low preempt ability: 1 forbids the channel from preempting |
| rr_mode_i | input | 1 | 1: round-robin, 0: fixed priority |
| halt_on_err_i | input | 1 | 1: any error halts new starts |
| debug_i | input | 1 | 1: hold off new starts |
| done_i | input | 1 | Engine finished the active channel |
| err_i | input | 1 | Engine error on the active channel |
| halt_clr_i | input | 1 | Clears halt and recorded error |
| grant_o | output | 1 | One-cycle pulse: a channel is started or resumed |
| grant_ch_o | output | CHW | Channel of the latest grant |
| resume_o | output | 1 | Pulses with grant_o when the grant restarts the suspended channel |
| suspend_o | output | 1 | Pulses with grant_o when the active channel was preempted |
| active_o | output | 1 | Engine is serving a channel |
| active_ch_o | output | CHW | Channel being served |
| prio_err_o | output | 1 | Priority values are not unique |
| halted_o | output | 1 | Arbiter halted by an error |
| err_valid_o | output | 1 | Sticky: an error has been recorded |
| err_ch_o | output | CHW | Channel of the last engine error |

## Verification
Every decision is made on the edge that samples the request, mode and gating inputs. Grant, suspend, resume, active and error results therefore appear one edge after the stimulus, and a halt clear takes effect one edge before the next grant can start. The bench drives inputs just after an edge, steps exactly one edge, and samples one time unit later. Each check sits at the first cycle in which the result is due, and the one-cycle pulses are checked to be gone on the cycle that follows. Fixed and rotating selection are swept over all fifteen request patterns. Preemption is swept over every ordered channel pair and all four permission combinations, with the expected outcome computed from the priority comparison.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        DEC_NONE    = 2'd0,
        DEC_NEW     = 2'd1,
        DEC_RESUME  = 2'd2,
        DEC_PREEMPT = 2'd3
    } dec_e;

    // index reached by stepping k places up from base, wrapping at n
    function automatic int wrap_add(input int base, input int k, input int n);
        int s;
        s = base + k;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NCH  = 4,
    parameter int PRIW = 2,
    parameter int CHW  = 2
) (
    input  logic [NCH-1:0]      cand,
    input  logic [NCH*PRIW-1:0] prio_flat,
    output logic                found,
    output logic [CHW-1:0]      idx,
    output logic [PRIW-1:0]     pval
);
    // largest value wins, lowest index on ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        pval  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cand[i] && (!found || prio_flat[i*PRIW +: PRIW] > pval)) begin
                found = 1'b1;
                idx   = CHW'(i);
                pval  = prio_flat[i*PRIW +: PRIW];
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
    import arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] cand,
    input  logic [CHW-1:0] last,
    output logic           found,
    output logic [CHW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= NCH; k++) begin
            if (!found && cand[wrap_add(int'(last), k, NCH)]) begin
                found = 1'b1;
                idx   = CHW'(wrap_add(int'(last), k, NCH));
            end
        end
    end
endmodule

// File: rtl/arb_prio_dup.sv
module arb_prio_dup #(
    parameter int NCH  = 4,
    parameter int PRIW = 2
) (
    input  logic [NCH*PRIW-1:0] prio_flat,
    output logic                dup
);
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = i + 1; j < NCH; j++) begin
                if (prio_flat[i*PRIW +: PRIW] == prio_flat[j*PRIW +: PRIW]) dup = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import arb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int PRIW = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      req_i,
    input  logic [NCH*PRIW-1:0] prio_i,
    input  logic [NCH-1:0]      yield_en_i,
    input  logic [NCH-1:0]      preempt_dis_i,
    input  logic                rr_mode_i,
    input  logic                halt_on_err_i,
    input  logic                debug_i,
    input  logic                done_i,
    input  logic                err_i,
    input  logic                halt_clr_i,
    output logic                grant_o,
    output logic [CHW-1:0]      grant_ch_o,
    output logic                resume_o,
    output logic                suspend_o,
    output logic                active_o,
    output logic [CHW-1:0]      active_ch_o,
    output logic                prio_err_o,
    output logic                halted_o,
    output logic                err_valid_o,
    output logic [CHW-1:0]      err_ch_o
);
    logic [PRIW-1:0] prio [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign prio[g] = prio_i[g*PRIW +: PRIW];
    end

    // suspension slot and rotation pointer
    logic           susp_valid;
    logic [CHW-1:0] susp_ch;
    logic [CHW-1:0] last_gnt;

    logic [NCH-1:0] act_mask, susp_mask, new_cand, pre_cand;
    always_comb begin
        act_mask  = '0;
        susp_mask = '0;
        if (active_o)   act_mask[active_ch_o] = 1'b1;
        if (susp_valid) susp_mask[susp_ch]    = 1'b1;
        new_cand = req_i & ~susp_mask & ~act_mask;
        pre_cand = new_cand & ~preempt_dis_i;
    end

    logic            nf, pf, rf, dup;
    logic [CHW-1:0]  nidx, pidx, ridx;
    logic [PRIW-1:0] np, pp;

    arb_prio_pick #(.NCH(NCH), .PRIW(PRIW), .CHW(CHW)) u_pick_new (
        .cand(new_cand), .prio_flat(prio_i), .found(nf), .idx(nidx), .pval(np));
    arb_prio_pick #(.NCH(NCH), .PRIW(PRIW), .CHW(CHW)) u_pick_pre (
        .cand(pre_cand), .prio_flat(prio_i), .found(pf), .idx(pidx), .pval(pp));
    arb_rr_pick #(.NCH(NCH), .CHW(CHW)) u_rr (
        .cand(new_cand), .last(last_gnt), .found(rf), .idx(ridx));
    arb_prio_dup #(.NCH(NCH), .PRIW(PRIW)) u_dup (
        .prio_flat(prio_i), .dup(dup));

    logic           gate_ok;
    dec_e           dec;
    logic [CHW-1:0] dec_ch;

    always_comb begin
        gate_ok = !halted_o && !debug_i;
        dec     = DEC_NONE;
        dec_ch  = '0;
        if (active_o) begin
            if (!done_i && gate_ok && !rr_mode_i && !susp_valid &&
                yield_en_i[active_ch_o] && pf && (pp > prio[active_ch_o])) begin
                dec    = DEC_PREEMPT;
                dec_ch = pidx;
            end
        end else if (gate_ok) begin
            if (susp_valid) begin
                if (!rr_mode_i && nf && (np > prio[susp_ch])) begin
                    dec    = DEC_NEW;
                    dec_ch = nidx;
                end else begin
                    dec    = DEC_RESUME;
                    dec_ch = susp_ch;
                end
            end else if (rr_mode_i) begin
                if (rf) begin
                    dec    = DEC_NEW;
                    dec_ch = ridx;
                end
            end else if (nf) begin
                dec    = DEC_NEW;
                dec_ch = nidx;
            end
        end
    end

    logic eng_err;
    assign eng_err = err_i && active_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o     <= 1'b0;
            grant_ch_o  <= '0;
            resume_o    <= 1'b0;
            suspend_o   <= 1'b0;
            active_o    <= 1'b0;
            active_ch_o <= '0;
            susp_valid  <= 1'b0;
            susp_ch     <= '0;
            last_gnt    <= CHW'(NCH - 1);
            prio_err_o  <= 1'b0;
            halted_o    <= 1'b0;
            err_valid_o <= 1'b0;
            err_ch_o    <= '0;
        end else begin
            grant_o   <= (dec != DEC_NONE);
            resume_o  <= (dec == DEC_RESUME);
            suspend_o <= (dec == DEC_PREEMPT);
            if (dec != DEC_NONE) begin
                grant_ch_o <= dec_ch;
                last_gnt   <= dec_ch;
            end
            case (dec)
                DEC_NEW: begin
                    active_o    <= 1'b1;
                    active_ch_o <= dec_ch;
                end
                DEC_RESUME: begin
                    active_o    <= 1'b1;
                    active_ch_o <= dec_ch;
                    susp_valid  <= 1'b0;
                end
                DEC_PREEMPT: begin
                    susp_valid  <= 1'b1;
                    susp_ch     <= active_ch_o;
                    active_ch_o <= dec_ch;
                end
                default: begin
                    if (active_o && done_i) active_o <= 1'b0;
                end
            endcase

            prio_err_o <= dup;
            if (halt_clr_i) begin
                halted_o    <= 1'b0;
                err_valid_o <= 1'b0;
            end
            if (eng_err) begin
                err_valid_o <= 1'b1;
                err_ch_o    <= active_ch_o;
            end
            if (dup) err_valid_o <= 1'b1;
            if (halt_on_err_i && (eng_err || dup)) halted_o <= 1'b1;
        end
    end

    // R1: a plain grant only starts from an idle engine
    a_r1_idle_grant: assert property (@(posedge clk) disable iff (rst)
        (grant_o && !suspend_o) |-> !$past(active_o));

    // R3: a suspension always hands the engine to a different channel
    a_r3_suspend_swap: assert property (@(posedge clk) disable iff (rst)
        suspend_o |-> (grant_o && $past(active_o) && (active_ch_o != $past(active_ch_o))));

    // R4: round-robin mode never preempts
    a_r4_rr_no_suspend: assert property (@(posedge clk) disable iff (rst)
        suspend_o |-> !$past(rr_mode_i));

    // R7: an error record needs an engine error or a priority clash
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_valid_o) |-> ($past(err_i && active_o) || $past(dup)));

    // R8: nothing starts while halted
    a_r8_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> !$past(halted_o));

    // R9: nothing starts in debug
    a_r9_debug_blocks: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> !$past(debug_i));

endmodule

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;
    localparam int NCH = 4;
    localparam int PRIW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic [NCH-1:0] req_i, yield_en_i, preempt_dis_i;
    logic [NCH*PRIW-1:0] prio_i;
    logic rr_mode_i, halt_on_err_i, debug_i, done_i, err_i, halt_clr_i;
    logic grant_o, resume_o, suspend_o, active_o, prio_err_o, halted_o, err_valid_o;
    logic [1:0] grant_ch_o, active_ch_o, err_ch_o;

    dma_chan_arbiter #(.NCH(NCH), .PRIW(PRIW)) u_dma_chan_arbiter (
        .clk(clk), .rst(rst), .req_i(req_i), .prio_i(prio_i),
        .yield_en_i(yield_en_i), .preempt_dis_i(preempt_dis_i),
        .rr_mode_i(rr_mode_i), .halt_on_err_i(halt_on_err_i), .debug_i(debug_i),
        .done_i(done_i), .err_i(err_i), .halt_clr_i(halt_clr_i),
        .grant_o(grant_o), .grant_ch_o(grant_ch_o), .resume_o(resume_o),
        .suspend_o(suspend_o), .active_o(active_o), .active_ch_o(active_ch_o),
        .prio_err_o(prio_err_o), .halted_o(halted_o), .err_valid_o(err_valid_o),
        .err_ch_o(err_ch_o));

    int vecs = 0;
    int errs = 0;
    int lastg = NCH - 1;
    int pr [NCH];

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put_prio();
        for (int i = 0; i < NCH; i++) prio_i[i*PRIW +: PRIW] = PRIW'(pr[i]);
    endtask

    function automatic int exp_fixed(input int pat);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < NCH; i++)
            if (pat[i] && pr[i] > bp) begin best = i; bp = pr[i]; end
        return best;
    endfunction

    function automatic int exp_rr(input int pat, input int last);
        for (int k = 1; k <= NCH; k++)
            if (pat[(last + k) % NCH]) return (last + k) % NCH;
        return -1;
    endfunction

    // end the active channel and leave the engine idle
    task automatic finish();
        req_i = '0;
        done_i = 1'b1;
        step();
        done_i = 1'b0;
    endtask

    task automatic clear_err();
        halt_clr_i = 1'b1;
        step();
        halt_clr_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_i = '0; yield_en_i = '1; preempt_dis_i = '0;
        rr_mode_i = 0; halt_on_err_i = 0; debug_i = 0;
        done_i = 0; err_i = 0; halt_clr_i = 0;
        for (int i = 0; i < NCH; i++) pr[i] = i;
        put_prio();
        repeat (3) step();
        chk("R1 reset grant", grant_o, 0);
        chk("R1 reset active", active_o, 0);
        chk("R8 reset halted", halted_o, 0);
        chk("R7 reset err_valid", err_valid_o, 0);
        rst = 1'b0;
        step();

        // R1: fixed-priority sweep
        pr[0] = 2; pr[1] = 0; pr[2] = 3; pr[3] = 1;
        put_prio();
        for (int pat = 1; pat < 16; pat++) begin
            req_i = NCH'(pat);
            step();
            chk("R1 grant pulse", grant_o, 1);
            chk("R1 grant channel", grant_ch_o, exp_fixed(pat));
            chk("R1 active channel", active_ch_o, exp_fixed(pat));
            lastg = exp_fixed(pat);
            finish();
            chk("R1 idle after done", active_o, 0);
            chk("R1 grant one cycle", grant_o, 0);
        end

        // R2: round-robin sweep, twice round
        rr_mode_i = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int pat = 1; pat < 16; pat++) begin
                req_i = NCH'(pat);
                step();
                chk("R2 rr grant", grant_o, 1);
                chk("R2 rr channel", grant_ch_o, exp_rr(pat, lastg));
                lastg = exp_rr(pat, lastg);
                finish();
            end
        end

        // R4: no preemption in round-robin mode
        for (int i = 0; i < NCH; i++) pr[i] = i;
        put_prio();
        step();
        req_i = 4'b0001;
        step();
        chk("R4 rr start ch0", active_ch_o, exp_rr(1, lastg));
        lastg = exp_rr(1, lastg);
        req_i = 4'b1001;
        step();
        chk("R4 rr no suspend", suspend_o, 0);
        chk("R4 rr keeps active", active_ch_o, lastg);
        finish();
        rr_mode_i = 1'b0;

        // R3/R4/R5: preemption over every pair and permission combination
        for (int a = 0; a < NCH; a++) begin
            for (int b = 0; b < NCH; b++) begin
                if (a == b) continue;
                for (int e = 0; e < 2; e++) begin
                    for (int d = 0; d < 2; d++) begin
                        bit exp_s;
                        yield_en_i = '1; yield_en_i[a] = e[0];
                        preempt_dis_i = '0; preempt_dis_i[b] = d[0];
                        exp_s = (b > a) && (e == 1) && (d == 0);
                        req_i = '0; req_i[a] = 1'b1;
                        step();
                        chk("R3 start victim", active_ch_o, a);
                        req_i[b] = 1'b1;
                        step();
                        chk(exp_s ? "R3 suspend" : "R4 no suspend", suspend_o, int'(exp_s));
                        chk(exp_s ? "R3 new active" : "R4 keep active", active_ch_o, exp_s ? b : a);
                        finish();
                        chk("R3 engine idle", active_o, 0);
                        if (exp_s) begin
                            step();
                            chk("R5 resume pulse", resume_o, 1);
                            chk("R5 resume channel", grant_ch_o, a);
                            finish();
                        end
                    end
                end
            end
        end
        yield_en_i = '1;
        preempt_dis_i = '0;

        // R5: suspended channel beats a lower new request
        req_i = 4'b0010; step();
        req_i = 4'b1010; step();
        chk("R5 preempt by ch3", suspend_o, 1);
        req_i = 4'b0001; done_i = 1'b1; step(); done_i = 1'b0;
        step();
        chk("R5 resume over lower", resume_o, 1);
        chk("R5 resume ch1", grant_ch_o, 1);
        finish();

        // R5: a strictly higher new request goes first
        req_i = 4'b0010; step();
        req_i = 4'b1010; step();
        req_i = 4'b0100; done_i = 1'b1; step(); done_i = 1'b0;
        step();
        chk("R5 higher new first", grant_ch_o, 2);
        chk("R5 not a resume", resume_o, 0);
        finish();
        step();
        chk("R5 resume later", resume_o, 1);
        chk("R5 resume later ch1", grant_ch_o, 1);
        finish();

        // R5: equal priority new request waits
        pr[0] = 1; put_prio();
        req_i = 4'b0010; step();
        req_i = 4'b1010; step();
        req_i = 4'b0001; done_i = 1'b1; step(); done_i = 1'b0;
        step();
        chk("R5 resume over equal", grant_ch_o, 1);
        chk("R5 resume over equal pulse", resume_o, 1);
        finish();
        pr[0] = 0; put_prio();
        step();
        clear_err();

        // R6: duplicate priority detection
        step();
        chk("R6 unique no error", prio_err_o, 0);
        chk("R6 unique err_valid", err_valid_o, 0);
        pr[0] = 2; pr[1] = 2; pr[2] = 1; pr[3] = 0; put_prio();
        step();
        chk("R6 duplicate flag", prio_err_o, 1);
        chk("R6 duplicate err_valid", err_valid_o, 1);
        chk("R6 no halt when disabled", halted_o, 0);
        req_i = 4'b0011; step();
        chk("R1 tie lower index", grant_ch_o, 0);
        finish();
        for (int i = 0; i < NCH; i++) pr[i] = i;
        put_prio();
        step();
        chk("R6 flag follows config", prio_err_o, 0);
        chk("R6 err_valid sticky", err_valid_o, 1);
        clear_err();
        chk("R6 cleared", err_valid_o, 0);

        // R7: engine error capture, idle error ignored
        err_i = 1'b1; step(); err_i = 1'b0;
        chk("R7 idle error ignored", err_valid_o, 0);
        req_i = 4'b0100; step();
        err_i = 1'b1; step(); err_i = 1'b0;
        chk("R7 err_valid", err_valid_o, 1);
        chk("R7 err channel", err_ch_o, 2);
        chk("R7 no halt when disabled", halted_o, 0);
        finish();
        clear_err();

        // R8: halt on error
        halt_on_err_i = 1'b1;
        req_i = 4'b0010; step();
        err_i = 1'b1; step(); err_i = 1'b0;
        chk("R8 halted", halted_o, 1);
        chk("R8 err channel", err_ch_o, 1);
        chk("R8 active continues", active_o, 1);
        req_i = 4'b1010; step();
        chk("R8 no preempt halted", suspend_o, 0);
        chk("R8 no grant halted", grant_o, 0);
        finish();
        chk("R8 done accepted", active_o, 0);
        req_i = 4'b0100; step();
        chk("R8 no start halted", grant_o, 0);
        step();
        chk("R8 still idle", active_o, 0);
        halt_clr_i = 1'b1; step(); halt_clr_i = 1'b0;
        chk("R8 halt cleared", halted_o, 0);
        chk("R8 err cleared", err_valid_o, 0);
        chk("R8 no grant on clear edge", grant_o, 0);
        step();
        chk("R8 grant after clear", grant_o, 1);
        chk("R8 grant channel", grant_ch_o, 2);
        finish();
        halt_on_err_i = 1'b0;

        // R9: debug holds new starts only
        req_i = 4'b0001; step();
        debug_i = 1'b1;
        req_i = 4'b1001; step();
        chk("R9 no preempt in debug", suspend_o, 0);
        chk("R9 active kept", active_ch_o, 0);
        req_i = 4'b1000; done_i = 1'b1; step(); done_i = 1'b0;
        chk("R9 done accepted", active_o, 0);
        step();
        chk("R9 no start in debug", grant_o, 0);
        step();
        chk("R9 still no start", active_o, 0);
        debug_i = 1'b0; step();
        chk("R9 grant after debug", grant_o, 1);
        chk("R9 grant channel", grant_ch_o, 3);
        finish();

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule